// File: doc/BRIEF.md
# Ramped-FSK Chirp Quadrature NCO Core

This core is a numerically controlled oscillator that delivers one cosine sample and one sine sample on every clock. Its frequency word is not fixed. A frequency stage can hold one tone, or switch between two tones on a pin. It can also sweep toward whichever of two endpoint words a pin selects, or run an open-ended linear chirp. Sweeps advance by a delta word each time a programmable interval timer expires. A hold pin can pause the sweep.

Software writes 16-bit pieces of each word into a shadow set through a small write port. An update strobe copies the whole shadow set into the active set in one step, so a partly written word never reaches the datapath. The active frequency word feeds a 48-bit phase accumulator. The top 17 bits of that phase are taken, and one of two 14-bit phase offsets is added to them; a pin picks the offset. A quarter-wave table with linear interpolation then turns the phase into signed 12-bit samples.

Top module: `nco_chirp_core`

## Requirements
- R1: The async active-low reset `rst_n` is released through a two-flop synchroniser. While `rst_n` is low, both outputs read 0. All registers clear to 0, so the first samples after reset are I = 2047 and Q = 0.
- R2: Writes go to a shadow set. Each 48-bit word takes three addresses, lowest 16 bits first: tone A at 0..2, tone B at 3..5, delta at 6..8. The interval goes to 9. Offset 0 goes to 10 and offset 1 to 11, using data bits 13:0. Nothing written reaches the outputs until `upd` is high at a clock edge. That edge copies every shadow word into the active set.
- R3: With `mode` = 0 (single tone), the frequency word becomes active tone A on the next edge, whatever the `fsk` and `hold` pins are doing.
- R4: With `mode` = 1 (two-tone), the frequency word becomes tone B when `fsk` is 1 and tone A when `fsk` is 0, on the next edge.
- R5: With `mode` = 2 (ramped), the frequency word moves toward the endpoint that `fsk` selects (1 = tone B), by the unsigned delta. A step happens once every interval+1 clocks. When the remaining gap is no larger than the delta, the word lands exactly on the endpoint and stays there. It never passes the endpoint.
- R6: If `fsk` changes during a ramp, the sweep turns back toward the other endpoint. It starts from the word it had reached, with no host action.
- R7: In modes 2 and 3, while `hold` is 1 the frequency word and the interval timer both keep their values.
- R8: With `mode` = 3 (chirp), each step adds the delta as a two's-complement value, wrapping modulo 2^48. The endpoints and `fsk` have no effect.
- R9: Each clock, the 48-bit phase accumulator adds the frequency word. Its bits 47:31 are added modulo 2^17 to the selected offset shifted left by 3. `bpsk` = 1 selects offset 1.
- R10: With p the offset phase, I equals round(2047*cos(2*pi*p/2^17)) and Q equals round(2047*sin(2*pi*p/2^17)), each within 1 LSB. Both are registered. Neither output ever shows -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 4 | Shadow register address |
| wr_data | input | 16 | Shadow register write data |
| upd | input | 1 | Copy shadow set to active set |
| mode | input | 2 | 0 tone, 1 two-tone, 2 ramped, 3 chirp |
| fsk | input | 1 | Endpoint / tone select |
| hold | input | 1 | Freeze the sweep |
| bpsk | input | 1 | Phase offset select |
| i_out | output | 12 | Signed cosine sample |
| q_out | output | 12 | Signed sine sample |

## Verification
Suppose an update strobe or a pin change is sampled at edge k. The active set, or the frequency word, changes at edge k. The phase accumulator sees the new frequency word from edge k+1. The samples carry that phase from edge k+2. A change of `bpsk` or of the active offset shows in the samples at edge k+1. The bench reference model steps through these same edges on every rising edge, using the pin values driven at the previous falling edge. It compares I and Q against the DUT at every falling edge. The explicit checks after a reset or a strobe wait at least four edges, so each result has settled before it is sampled.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    M_TONE  = 2'd0,
    M_FSK   = 2'd1,
    M_RAMP  = 2'd2,
    M_CHIRP = 2'd3
  } nco_mode_e;
endpackage

// File: rtl/nco_regs.sv
module nco_regs #(
  parameter int FW  = 48,
  parameter int RW  = 16,
  parameter int OFW = 14,
  parameter int DW  = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           upd,
  output logic [FW-1:0]  f1_a,
  output logic [FW-1:0]  f2_a,
  output logic [FW-1:0]  dlt_a,
  output logic [RW-1:0]  rate_a,
  output logic [OFW-1:0] off0_a,
  output logic [OFW-1:0] off1_a
);
  localparam int NSEG = FW / DW;
  localparam int A_F1 = 0;
  localparam int A_F2 = NSEG;
  localparam int A_DL = 2 * NSEG;
  localparam int A_RT = 3 * NSEG;
  localparam int A_O0 = A_RT + 1;
  localparam int A_O1 = A_RT + 2;

  logic [FW-1:0]  f1_s, f2_s, dlt_s, f1_d, f2_d, dlt_d;
  logic [RW-1:0]  rate_s, rate_d;
  logic [OFW-1:0] off0_s, off1_s, off0_d, off1_d;

  // shadow next-state
  always_comb begin
    f1_d   = f1_s;
    f2_d   = f2_s;
    dlt_d  = dlt_s;
    rate_d = rate_s;
    off0_d = off0_s;
    off1_d = off1_s;
    for (int s = 0; s < NSEG; s++) begin
      if (wr_addr == AW'(A_F1 + s)) f1_d[s*DW +: DW]  = wr_data;
      if (wr_addr == AW'(A_F2 + s)) f2_d[s*DW +: DW]  = wr_data;
      if (wr_addr == AW'(A_DL + s)) dlt_d[s*DW +: DW] = wr_data;
    end
    if (wr_addr == AW'(A_RT)) rate_d = wr_data[RW-1:0];
    if (wr_addr == AW'(A_O0)) off0_d = wr_data[OFW-1:0];
    if (wr_addr == AW'(A_O1)) off1_d = wr_data[OFW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_s   <= '0;
      f2_s   <= '0;
      dlt_s  <= '0;
      rate_s <= '0;
      off0_s <= '0;
      off1_s <= '0;
    end else if (wr_en) begin
      f1_s   <= f1_d;
      f2_s   <= f2_d;
      dlt_s  <= dlt_d;
      rate_s <= rate_d;
      off0_s <= off0_d;
      off1_s <= off1_d;
    end
  end

  // active set, enabled by the update strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_a   <= '0;
      f2_a   <= '0;
      dlt_a  <= '0;
      rate_a <= '0;
      off0_a <= '0;
      off1_a <= '0;
    end else if (upd) begin
      f1_a   <= f1_s;
      f2_a   <= f2_s;
      dlt_a  <= dlt_s;
      rate_a <= rate_s;
      off0_a <= off0_s;
      off1_a <= off1_s;
    end
  end

  // R2: without a strobe the active set does not move
  a_r2_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(f1_a) && $stable(f2_a) && $stable(dlt_a) &&
              $stable(rate_a) && $stable(off0_a) && $stable(off1_a)));
endmodule

// File: rtl/nco_freq_ctl.sv
module nco_freq_ctl
  import nco_pkg::*;
#(
  parameter int FW = 48,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nco_mode_e     mode,
  input  logic          fsk,
  input  logic          hold,
  input  logic [FW-1:0] f1,
  input  logic [FW-1:0] f2,
  input  logic [FW-1:0] dlt,
  input  logic [RW-1:0] rate,
  output logic [FW-1:0] freq
);
  logic [FW-1:0] acc_q, acc_d, tgt, up_gap, dn_gap;
  logic [RW-1:0] cnt_q, cnt_d;
  logic          sweeping, acc_en;

  always_comb begin
    tgt      = fsk ? f2 : f1;
    up_gap   = tgt - acc_q;
    dn_gap   = acc_q - tgt;
    sweeping = (mode == M_RAMP) || (mode == M_CHIRP);
    acc_en   = !(sweeping && hold);
    acc_d    = acc_q;
    cnt_d    = cnt_q;
    case (mode)
      M_TONE: begin
        acc_d = f1;
        cnt_d = '0;
      end
      M_FSK: begin
        acc_d = tgt;
        cnt_d = '0;
      end
      default: begin
        if (cnt_q == '0) begin
          cnt_d = rate;
          if (mode == M_CHIRP)  acc_d = acc_q + dlt;
          else if (acc_q < tgt) acc_d = (up_gap <= dlt) ? tgt : acc_q + dlt;
          else if (acc_q > tgt) acc_d = (dn_gap <= dlt) ? tgt : acc_q - dlt;
        end else begin
          cnt_d = cnt_q - RW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign freq = acc_q;

  a_r3_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TONE) |=> (acc_q == $past(f1)));
  a_r5_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RAMP && acc_q <= tgt) |=> (acc_q <= $past(tgt)));
  a_r5_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RAMP && acc_q >= tgt) |=> (acc_q >= $past(tgt)));
  a_r5_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && cnt_q != '0) |=> $stable(acc_q));
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && hold) |=> ($stable(acc_q) && $stable(cnt_q)));
endmodule

// File: rtl/nco_sine.sv
module nco_sine #(
  parameter int TW = 17,
  parameter int OW = 12,
  parameter int QB = 8
) (
  input  logic [TW-1:0]        phase,
  output logic signed [OW-1:0] amp
);
  localparam int FB    = TW - 2 - QB;
  localparam int QN    = 1 << QB;
  localparam int TAB_N = QN + 2;
  localparam int XS    = 4;
  localparam int TAB_W = OW + XS;
  localparam int AMP   = (1 << (OW - 1)) - 1;
  localparam int IW    = TW - 1 - FB;

  function automatic int sine_entry(int k);
    real a;
    a = 3.14159265358979 * 0.5 * real'(k) / real'(QN);
    return $rtoi(real'(AMP) * real'(1 << XS) * $sin(a) + 0.5);
  endfunction

  logic [TAB_W-1:0] tab [TAB_N];
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam int VAL = sine_entry(k);
    assign tab[k] = TAB_W'(VAL);
  end

  logic [1:0]    quad;
  logic [TW-3:0] x;
  logic [TW-2:0] m;
  logic [IW-1:0] idx, idx1;
  logic [FB-1:0] fr;
  int            base, nxt, lin, mag;

  always_comb begin
    quad = phase[TW-1:TW-2];
    x    = phase[TW-3:0];
    m    = quad[0] ? ((TW-1)'(1 << (TW - 2)) - {1'b0, x}) : {1'b0, x};
    idx  = m[TW-2:FB];
    idx1 = idx + IW'(1);
    fr   = m[FB-1:0];
    base = int'(tab[idx]);
    nxt  = int'(tab[idx1]);
    lin  = base * (1 << FB) + (nxt - base) * int'(fr);
    mag  = (lin + (1 << (FB + XS - 1))) >>> (FB + XS);
    amp  = quad[1] ? OW'(-mag) : OW'(mag);
  end
endmodule

// File: rtl/nco_chirp_core.sv
module nco_chirp_core
  import nco_pkg::*;
#(
  parameter int FW  = 48,
  parameter int RW  = 16,
  parameter int OFW = 14,
  parameter int TW  = 17,
  parameter int OW  = 12,
  parameter int QB  = 8,
  parameter int DW  = 16,
  parameter int AW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 upd,
  input  logic [1:0]           mode,
  input  logic                 fsk,
  input  logic                 hold,
  input  logic                 bpsk,
  output logic signed [OW-1:0] i_out,
  output logic signed [OW-1:0] q_out
);
  localparam int OSH = TW - OFW;

  logic [1:0]     rs_q;
  logic           rst_s;
  logic [FW-1:0]  f1_a, f2_a, dlt_a, freq_w, ph_q, ph_d;
  logic [RW-1:0]  rate_a;
  logic [OFW-1:0] off0_a, off1_a, off_sel;
  logic [TW-1:0]  rot, cph;
  logic signed [OW-1:0] s_amp, c_amp, i_q, q_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  nco_regs #(.FW(FW), .RW(RW), .OFW(OFW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd(upd), .f1_a(f1_a), .f2_a(f2_a),
    .dlt_a(dlt_a), .rate_a(rate_a), .off0_a(off0_a), .off1_a(off1_a)
  );

  nco_freq_ctl #(.FW(FW), .RW(RW)) u_freq (
    .clk(clk), .rst_n(rst_s), .mode(nco_mode_e'(mode)), .fsk(fsk),
    .hold(hold), .f1(f1_a), .f2(f2_a), .dlt(dlt_a), .rate(rate_a),
    .freq(freq_w)
  );

  always_comb begin
    ph_d    = ph_q + freq_w;
    off_sel = bpsk ? off1_a : off0_a;
    rot     = ph_q[FW-1 -: TW] + {off_sel, {OSH{1'b0}}};
    cph     = rot + {2'b01, {(TW-2){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  nco_sine #(.TW(TW), .OW(OW), .QB(QB)) u_sin (.phase(rot), .amp(s_amp));
  nco_sine #(.TW(TW), .OW(OW), .QB(QB)) u_cos (.phase(cph), .amp(c_amp));

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      i_q <= '0;
      q_q <= '0;
    end else begin
      i_q <= c_amp;
      q_q <= s_amp;
    end
  end

  assign i_out = i_q;
  assign q_out = q_q;

  a_r10_i_no_min: assert property (@(posedge clk) disable iff (!rst_s)
    i_q != {1'b1, {(OW-1){1'b0}}});
  a_r10_q_no_min: assert property (@(posedge clk) disable iff (!rst_s)
    q_q != {1'b1, {(OW-1){1'b0}}});
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_s |-> (i_q == '0 && q_q == '0));
endmodule

// File: tb/test_nco_chirp_core.sv
module test_nco_chirp_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        upd = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        fsk = 1'b0;
  logic        hold = 1'b0;
  logic        bpsk = 1'b0;
  logic signed [11:0] i_out, q_out;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  nco_chirp_core i_nco_chirp_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd(upd), .mode(mode), .fsk(fsk), .hold(hold),
    .bpsk(bpsk), .i_out(i_out), .q_out(q_out)
  );

  // ---------------- reference model ----------------
  logic [47:0] s_f1, s_f2, s_dl, a_f1, a_f2, a_dl, m_acc, m_ph;
  logic [15:0] s_rt, a_rt, m_cnt;
  logic [13:0] s_o0, s_o1, a_o0, a_o1;
  bit          rs1, rs2;
  int          exp_i, exp_q;

  function automatic int ampl(logic [16:0] p);
    real a;
    a = 2.0 * 3.14159265358979 * real'(p) / 131072.0;
    return int'(2047.0 * $sin(a));
  endfunction

  task automatic m_clear();
    s_f1 = '0; s_f2 = '0; s_dl = '0; s_rt = '0; s_o0 = '0; s_o1 = '0;
    a_f1 = '0; a_f2 = '0; a_dl = '0; a_rt = '0; a_o0 = '0; a_o1 = '0;
    m_acc = '0; m_ph = '0; m_cnt = '0; exp_i = 0; exp_q = 0;
  endtask

  task automatic m_step();
    logic [16:0] rot;
    logic [47:0] tgt, nacc;
    logic [15:0] ncnt;
    rot   = m_ph[47:31] + {(bpsk ? a_o1 : a_o0), 3'b000};
    exp_i = ampl(rot + 17'h08000);
    exp_q = ampl(rot);
    m_ph  = m_ph + m_acc;
    tgt   = fsk ? a_f2 : a_f1;
    nacc  = m_acc;
    ncnt  = m_cnt;
    if (mode == 2'd0) begin
      nacc = a_f1; ncnt = 0;
    end else if (mode == 2'd1) begin
      nacc = tgt; ncnt = 0;
    end else if (!hold) begin
      if (m_cnt == 0) begin
        ncnt = a_rt;
        if (mode == 2'd3) nacc = m_acc + a_dl;
        else if (m_acc < tgt) nacc = (tgt - m_acc <= a_dl) ? tgt : m_acc + a_dl;
        else if (m_acc > tgt) nacc = (m_acc - tgt <= a_dl) ? tgt : m_acc - a_dl;
      end else begin
        ncnt = m_cnt - 16'd1;
      end
    end
    m_acc = nacc;
    m_cnt = ncnt;
    if (upd) begin
      a_f1 = s_f1; a_f2 = s_f2; a_dl = s_dl; a_rt = s_rt; a_o0 = s_o0; a_o1 = s_o1;
    end
    if (wr_en) begin
      case (wr_addr)
        4'd0:  s_f1[15:0]  = wr_data;
        4'd1:  s_f1[31:16] = wr_data;
        4'd2:  s_f1[47:32] = wr_data;
        4'd3:  s_f2[15:0]  = wr_data;
        4'd4:  s_f2[31:16] = wr_data;
        4'd5:  s_f2[47:32] = wr_data;
        4'd6:  s_dl[15:0]  = wr_data;
        4'd7:  s_dl[31:16] = wr_data;
        4'd8:  s_dl[47:32] = wr_data;
        4'd9:  s_rt        = wr_data;
        4'd10: s_o0        = wr_data[13:0];
        4'd11: s_o1        = wr_data[13:0];
        default: ;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 1'b0; rs2 = 1'b0;
      m_clear();
    end else begin
      if (!rs2) m_clear();
      else      m_step();
      rs2 = rs1;
      rs1 = 1'b1;
    end
  end

  // ---------------- comparison on every clock ----------------
  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      checks++;
      if (absdiff(int'(i_out), exp_i) > 1 || absdiff(int'(q_out), exp_q) > 1) begin
        failures++;
        $display("FAIL %s cycle %0d: i=%0d q=%0d expected i=%0d q=%0d",
                 cur_req, cyc, i_out, q_out, exp_i, exp_q);
      end
    end
  end

  task automatic chk_iq(string req, int ei, int eq);
    checks++;
    if (absdiff(int'(i_out), ei) > 1 || absdiff(int'(q_out), eq) > 1) begin
      failures++;
      $display("FAIL %s: i=%0d q=%0d expected i=%0d q=%0d", req, i_out, q_out, ei, eq);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic w48(logic [3:0] base, logic [47:0] v);
    wreg(base, v[15:0]);
    wreg(base + 4'd1, v[31:16]);
    wreg(base + 4'd2, v[47:32]);
  endtask

  task automatic strobe();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    // R1: reset state, then first samples
    tick(5);
    chk_iq("R1", 0, 0);
    rst_n = 1'b1;
    tick(4);
    chk_iq("R1", 2047, 0);
    cmp_en = 1'b1;

    // R9: offsets with a frozen phase of zero
    cur_req = "R9";
    wreg(4'd10, 16'h2000);
    wreg(4'd11, 16'h1000);
    strobe();
    bpsk = 1'b1;
    tick(4);
    chk_iq("R9", 0, 2047);
    bpsk = 1'b0;
    tick(4);
    chk_iq("R9", -2047, 0);
    wreg(4'd10, 16'h0000);
    strobe();
    tick(4);
    chk_iq("R9", 2047, 0);

    // R2: shadow write without strobe has no effect
    cur_req = "R2";
    w48(4'd0, 48'h1000_0000_0000);
    tick(10);
    chk_iq("R2", 2047, 0);
    strobe();
    tick(40);

    // R3: single tone ignores fsk and hold
    cur_req = "R3";
    w48(4'd3, 48'h0800_0000_0000);
    strobe();
    fsk = 1'b1; hold = 1'b1;
    tick(30);
    hold = 1'b0;

    // R4: two-tone switching
    cur_req = "R4";
    mode = 2'd1;
    tick(20);
    fsk = 1'b0;
    tick(15);
    fsk = 1'b1;
    tick(7);
    fsk = 1'b0;
    tick(20);

    // R5: ramp up with clamp on a non-multiple gap
    cur_req = "R5";
    mode = 2'd0;
    w48(4'd3, 48'h1500_3039_0000);
    w48(4'd6, 48'h0100_0000_0000);
    wreg(4'd9, 16'd3);
    strobe();
    tick(5);
    mode = 2'd2;
    fsk = 1'b1;
    tick(60);

    // R6: reversal mid-sweep
    cur_req = "R6";
    fsk = 1'b0;
    tick(10);
    fsk = 1'b1;
    tick(6);
    fsk = 1'b0;
    tick(40);

    // R7: hold mid-sweep
    cur_req = "R7";
    fsk = 1'b1;
    tick(6);
    hold = 1'b1;
    tick(20);
    hold = 1'b0;
    tick(30);

    // R8: down chirp, every clock, fsk ignored
    cur_req = "R8";
    w48(4'd6, 48'hFFC0_0000_0000);
    wreg(4'd9, 16'd0);
    strobe();
    mode = 2'd3;
    tick(50);
    fsk = 1'b0;
    tick(50);
    hold = 1'b1;
    tick(10);
    hold = 1'b0;
    tick(20);

    // R10: fast tone with offset flips over many samples
    cur_req = "R10";
    mode = 2'd0;
    w48(4'd0, 48'h0123_4567_89AB);
    wreg(4'd11, 16'h0555);
    strobe();
    for (int n = 0; n < 10; n++) begin
      tick(30);
      bpsk = ~bpsk;
    end
    tick(20);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule